// File: doc/BRIEF.md
# Event Timer Comparator Channel

One comparator channel of a multi-channel event timer. The channel watches a shared, free-running 64-bit main counter that is supplied from outside. It emits a one-cycle fire strobe when the counter reaches the channel's comparator. In one-shot mode the channel fires once and then disarms. In periodic mode it keeps a hidden period and moves the comparator forward by that period after each fire. It can also run with a 32-bit operating width, in which case comparisons and arithmetic use only the low word of the counter.

Software reaches the channel through three write strobes that share one 32-bit data bus: one for the configuration word and one for each half of the comparator. The configuration word and the comparator value can be read back. Interrupt routing and the address decoder sit outside this block.

Top module: `ect_channel`

## Requirements
- R1: After reset the comparator reads all ones, the hidden period is zero, the configuration reads 0x30 (only the two capability flags set) and fire_o is low.
- R2: In one-shot mode an armed channel raises fire_o for exactly one cycle, one clock after the first tick_i cycle on which (count - comparator), taken as a signed value, is zero or positive. It then disarms and does not fire again.
- R3: The configuration word has these bits: bit0 channel enable, bit1 periodic, bit2 set-value, bit3 32-bit width. Bits 4 and 5 are read-only ones (periodic-capable, 64-bit-capable). All other bits read zero, and writes to them have no effect.
- R4: On a periodic fire with a non-zero period, the comparator gains the period. The channel then keeps adding the period, once per clock and without firing, until the comparator is ahead of the counter. With a zero period the channel behaves as one-shot.
- R5: While periodic mode is selected and set-value is clear, a write to either comparator half updates only the period, and the readable comparator is unchanged. With set-value set, a low-half write loads both the comparator and the period, and a high-half write loads only the comparator.
- R6: The set-value bit clears after any write to either comparator half.
- R7: The stored period always has its top bit clear: bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R8: A configuration write that selects 32-bit width zeroes the upper halves of the comparator and the period. In 32-bit mode, writes to the high halves are ignored, matching uses the signed 32-bit difference of the low words, and comparator advances wrap modulo 2^32.
- R9: In 32-bit one-shot mode, an armed channel fires once on the tick at which the counter's low word becomes zero before the match. It stays armed and fires again at the real match.
- R10: A rising channel-enable bit arms the channel when the global enable is high. A falling channel-enable bit disarms the channel. No fire occurs while either enable is low.
- R11: A rising global enable re-arms the channel when the comparator is not all ones. A low global enable disarms it.
- R12: A write to either comparator half while the global enable is high re-arms the channel, so a one-shot channel that has already fired can fire again.
- R13: Matches are evaluated only in cycles with tick_i high. A counter value that passes the comparator without tick_i produces no fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Shared main counter value |
| tick_i | input | 1 | Counter advanced this cycle; match is evaluated |
| glb_en_i | input | 1 | Global timer enable |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cmp_lo_wr_i | input | 1 | Comparator low-half write strobe |
| cmp_hi_wr_i | input | 1 | Comparator high-half write strobe |
| wdata_i | input | 32 | Write data shared by all strobes |
| fire_o | output | 1 | One-cycle fire strobe |
| cfg_o | output | 32 | Configuration readback |
| cmp_o | output | 64 | Comparator readback |

## Verification
The hardest states to reach from the ports are the periodic catch-up run and the 32-bit wrap fire. The catch-up run needs the counter to jump several periods past the comparator in a single tick. The wrap fire needs the counter's low word to sit just below the 32-bit boundary while a high word is present that would make a 64-bit compare give the opposite answer. The stimulus drives count_i directly, so it jumps the counter to those values, and it checks the comparator readback after each catch-up step. A behavioural reference model runs alongside the design and compares fire_o, cfg_o and cmp_o on every clock.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int unsigned CFG_EN   = 0;
  localparam int unsigned CFG_PER  = 1;
  localparam int unsigned CFG_SV   = 2;
  localparam int unsigned CFG_W32  = 3;
  localparam int unsigned CFG_PCAP = 4;
  localparam int unsigned CFG_WCAP = 5;
  localparam int unsigned CFG_WBITS = 4;
endpackage

// File: rtl/ect_cfg_reg.sv
module ect_cfg_reg
  import ect_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [CFG_WBITS-1:0] wdata_i,
  input  logic                 sv_clr_i,
  output logic                 en_o,
  output logic                 per_o,
  output logic                 sv_o,
  output logic                 w32_o,
  output logic                 en_rise_o,
  output logic                 en_fall_o,
  output logic                 trunc_o,
  output logic [HALF_W-1:0]    cfg_o
);
  logic en_q, per_q, sv_q, w32_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      per_q <= 1'b0;
      sv_q  <= 1'b0;
      w32_q <= 1'b0;
    end else begin
      if (wr_i) begin
        en_q  <= wdata_i[CFG_EN];
        per_q <= wdata_i[CFG_PER];
        sv_q  <= wdata_i[CFG_SV];
        w32_q <= wdata_i[CFG_W32];
      end
      if (sv_clr_i) sv_q <= 1'b0;  // comparator write wins
    end
  end

  always_comb begin
    en_o      = en_q;
    per_o     = per_q;
    sv_o      = sv_q;
    w32_o     = w32_q;
    en_rise_o = wr_i &  wdata_i[CFG_EN] & ~en_q;
    en_fall_o = wr_i & ~wdata_i[CFG_EN] &  en_q;
    trunc_o   = wr_i &  wdata_i[CFG_W32];
    cfg_o           = '0;
    cfg_o[CFG_EN]   = en_q;
    cfg_o[CFG_PER]  = per_q;
    cfg_o[CFG_SV]   = sv_q;
    cfg_o[CFG_W32]  = w32_q;
    cfg_o[CFG_PCAP] = 1'b1;
    cfg_o[CFG_WCAP] = 1'b1;
  end

  // R6
  a_r6_setval_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sv_clr_i |=> !sv_q);
endmodule

// File: rtl/ect_cmp_store.sv
module ect_cmp_store #(
  parameter int unsigned CNT_W = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [CNT_W/2-1:0]    wdata_i,
  input  logic                  per_mode_i,
  input  logic                  sv_i,
  input  logic                  w32_i,
  input  logic                  trunc_i,
  input  logic                  advance_i,
  output logic [CNT_W-1:0]      cmp_o,
  output logic                  period_nz_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  cmp_q, per_q, cmp_d, per_d, sum;
  logic [HALF_W-1:0] per_lo_msk, per_hi_msk;
  logic              load_cmp;

  always_comb begin
    load_cmp   = ~per_mode_i | sv_i;
    sum        = cmp_q + per_q;
    if (w32_i) sum[CNT_W-1:HALF_W] = '0;
    per_lo_msk = w32_i ? {1'b0, wdata_i[HALF_W-2:0]} : wdata_i;
    per_hi_msk = {1'b0, wdata_i[HALF_W-2:0]};
    cmp_d = cmp_q;
    per_d = per_q;
    if (wr_lo_i) begin
      if (load_cmp)   cmp_d[HALF_W-1:0] = wdata_i;
      if (per_mode_i) per_d[HALF_W-1:0] = per_lo_msk;
    end
    if (wr_hi_i && !w32_i) begin
      if (load_cmp) cmp_d[CNT_W-1:HALF_W] = wdata_i;
      else          per_d[CNT_W-1:HALF_W] = per_hi_msk;
    end
    if (advance_i && !wr_lo_i && !wr_hi_i) cmp_d = sum;
    if (trunc_i) begin
      cmp_d[CNT_W-1:HALF_W] = '0;
      per_d[CNT_W-1:HALF_W] = '0;
      per_d[HALF_W-1]       = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
    end
  end

  assign cmp_o       = cmp_q;
  assign period_nz_o = |per_q;

  // R7
  a_r7_period_msb_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_q[CNT_W-1] && (!w32_i || !per_q[HALF_W-1]));
  // R8
  a_r8_upper_zero_w32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w32_i |-> (cmp_q[CNT_W-1:HALF_W] == '0) && (per_q[CNT_W-1:HALF_W] == '0));
endmodule

// File: rtl/ect_match_eval.sv
module ect_match_eval #(
  parameter int unsigned CNT_W = 64
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             w32_i,
  output logic             reached_o,
  output logic             wrap_o,
  output logic             all_ones_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] diff;

  always_comb begin
    diff       = count_i - cmp_i;
    reached_o  = w32_i ? ~diff[HALF_W-1] : ~diff[CNT_W-1];
    wrap_o     = (count_i[HALF_W-1:0] == '0);
    all_ones_o = &cmp_i;
  end
endmodule

// File: rtl/ect_arm_ctrl.sv
module ect_arm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic glb_en_i,
  input  logic en_i,
  input  logic per_mode_i,
  input  logic w32_i,
  input  logic period_nz_i,
  input  logic reached_i,
  input  logic wrap_i,
  input  logic all_ones_i,
  input  logic en_rise_i,
  input  logic en_fall_i,
  input  logic cmp_wr_i,
  output logic fire_o,
  output logic advance_o
);
  logic armed_q, catch_q, wrapd_q, glb_q, fire_q;
  logic live, chk, hit, whit, keep, adv, arm_evt, glb_rise;

  always_comb begin
    glb_rise = glb_en_i & ~glb_q;
    live     = armed_q & en_i & glb_en_i;
    chk      = live & tick_i & ~catch_q;
    hit      = chk & reached_i;
    whit     = chk & ~reached_i & w32_i & ~per_mode_i & wrap_i & ~wrapd_q;
    keep     = hit & per_mode_i & period_nz_i;
    adv      = keep | (catch_q & live & reached_i);
    arm_evt  = (cmp_wr_i & glb_en_i) | (glb_rise & ~all_ones_i) | (en_rise_i & glb_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      catch_q <= 1'b0;
      wrapd_q <= 1'b0;
      glb_q   <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      glb_q  <= glb_en_i;
      fire_q <= hit | whit;
      if (cmp_wr_i || en_fall_i || !glb_en_i) catch_q <= 1'b0;
      else                                    catch_q <= adv;
      if (en_fall_i || !glb_en_i) armed_q <= 1'b0;
      else if (arm_evt)           armed_q <= 1'b1;
      else if (hit && !keep)      armed_q <= 1'b0;
      if (arm_evt)   wrapd_q <= 1'b0;
      else if (whit) wrapd_q <= 1'b1;
    end
  end

  assign fire_o    = fire_q;
  assign advance_o = adv;

  // R13
  a_r13_fire_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(tick_i));
  // R10
  a_r10_fire_needs_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(en_i && glb_en_i));
  // R4
  a_r4_no_fire_in_catchup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    catch_q |=> !fire_o);
  // R11
  a_r11_glb_low_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> !armed_q && !catch_q);
endmodule

// File: rtl/ect_channel.sv
module ect_channel
  import ect_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    count_i,
  input  logic                tick_i,
  input  logic                glb_en_i,
  input  logic                cfg_wr_i,
  input  logic                cmp_lo_wr_i,
  input  logic                cmp_hi_wr_i,
  input  logic [CNT_W/2-1:0]  wdata_i,
  output logic                fire_o,
  output logic [CNT_W/2-1:0]  cfg_o,
  output logic [CNT_W-1:0]    cmp_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic en, per_mode, sv, w32, en_rise, en_fall, trunc;
  logic reached, wrap, all_ones, period_nz, advance, cmp_wr;
  logic [CNT_W-1:0] cmp;

  assign cmp_wr = cmp_lo_wr_i | cmp_hi_wr_i;

  ect_cfg_reg #(.HALF_W(HALF_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr_i),
    .wdata_i   (wdata_i[CFG_WBITS-1:0]),
    .sv_clr_i  (cmp_wr),
    .en_o      (en),
    .per_o     (per_mode),
    .sv_o      (sv),
    .w32_o     (w32),
    .en_rise_o (en_rise),
    .en_fall_o (en_fall),
    .trunc_o   (trunc),
    .cfg_o     (cfg_o)
  );

  ect_cmp_store #(.CNT_W(CNT_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_lo_i     (cmp_lo_wr_i),
    .wr_hi_i     (cmp_hi_wr_i),
    .wdata_i     (wdata_i),
    .per_mode_i  (per_mode),
    .sv_i        (sv),
    .w32_i       (w32),
    .trunc_i     (trunc),
    .advance_i   (advance),
    .cmp_o       (cmp),
    .period_nz_o (period_nz)
  );

  ect_match_eval #(.CNT_W(CNT_W)) u_match (
    .count_i    (count_i),
    .cmp_i      (cmp),
    .w32_i      (w32),
    .reached_o  (reached),
    .wrap_o     (wrap),
    .all_ones_o (all_ones)
  );

  ect_arm_ctrl u_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .glb_en_i    (glb_en_i),
    .en_i        (en),
    .per_mode_i  (per_mode),
    .w32_i       (w32),
    .period_nz_i (period_nz),
    .reached_i   (reached),
    .wrap_i      (wrap),
    .all_ones_i  (all_ones),
    .en_rise_i   (en_rise),
    .en_fall_i   (en_fall),
    .cmp_wr_i    (cmp_wr),
    .fire_o      (fire_o),
    .advance_o   (advance)
  );

  assign cmp_o = cmp;
endmodule

// File: tb/ect_channel_test.sv
module ect_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count = '0;
  logic        tick = 1'b0, glb = 1'b0, cfg_wr = 1'b0, lo_wr = 1'b0, hi_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        fire_o;
  logic [31:0] cfg_o;
  logic [63:0] cmp_o;

  int n_chk = 0, n_fail = 0, n_fire = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  ect_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count), .tick_i(tick), .glb_en_i(glb),
    .cfg_wr_i(cfg_wr), .cmp_lo_wr_i(lo_wr), .cmp_hi_wr_i(hi_wr), .wdata_i(wdata),
    .fire_o(fire_o), .cfg_o(cfg_o), .cmp_o(cmp_o)
  );

  // behavioural reference model
  bit [63:0] m_cmp, m_per;
  bit m_en, m_pm, m_sv, m_w32, m_arm, m_cu, m_wd, m_fire, m_gq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmp = '1; m_per = '0;
      {m_en, m_pm, m_sv, m_w32, m_arm, m_cu, m_wd, m_fire, m_gq} = '0;
    end else begin
      bit [63:0] d;
      bit reach, live, hit, whit, keep, adv, arm, any_wr, efall, erise;
      d      = count - m_cmp;
      reach  = m_w32 ? !d[31] : !d[63];
      live   = m_arm && m_en && glb;
      hit    = live && tick && !m_cu && reach;
      whit   = live && tick && !m_cu && !reach && m_w32 && !m_pm &&
               (count[31:0] == 0) && !m_wd;
      keep   = hit && m_pm && (m_per != 0);
      adv    = keep || (m_cu && live && reach);
      any_wr = lo_wr || hi_wr;
      erise  = cfg_wr && wdata[0] && !m_en;
      efall  = cfg_wr && !wdata[0] && m_en;
      arm    = (any_wr && glb) || (glb && !m_gq && m_cmp != '1) || (erise && glb);
      m_fire = hit || whit;
      // comparator / period
      if (lo_wr) begin
        if (!m_pm || m_sv) m_cmp[31:0] = wdata;
        if (m_pm) m_per[31:0] = m_w32 ? (wdata & 32'h7FFF_FFFF) : wdata;
      end
      if (hi_wr && !m_w32) begin
        if (!m_pm || m_sv) m_cmp[63:32] = wdata;
        else m_per[63:32] = wdata & 32'h7FFF_FFFF;
      end
      if (adv && !any_wr) begin
        m_cmp = m_cmp + m_per;
        if (m_w32) m_cmp[63:32] = 0;
      end
      if (cfg_wr && wdata[3]) begin
        m_cmp[63:32] = 0; m_per[63:31] = 0;
      end
      // arming
      m_cu = (any_wr || efall || !glb) ? 1'b0 : adv;
      if (efall || !glb) m_arm = 0;
      else if (arm) m_arm = 1;
      else if (hit && !keep) m_arm = 0;
      if (arm) m_wd = 0; else if (whit) m_wd = 1;
      m_gq = glb;
      if (cfg_wr) begin
        m_en = wdata[0]; m_pm = wdata[1]; m_sv = wdata[2]; m_w32 = wdata[3];
      end
      if (any_wr) m_sv = 0;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (fire_o) n_fire++;
    chk({cur_req, " fire"}, {63'd0, fire_o}, {63'd0, m_fire});
    chk({cur_req, " cmp"}, cmp_o, m_cmp);
    chk({cur_req, " cfg"}, {32'd0, cfg_o}, {32'd0, 26'd0, 2'b11, m_w32, m_sv, m_pm, m_en});
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic wr_cfg(logic [31:0] v);
    cfg_wr = 1; wdata = v; cyc(); cfg_wr = 0;
  endtask
  task automatic wr_lo(logic [31:0] v);
    lo_wr = 1; wdata = v; cyc(); lo_wr = 0;
  endtask
  task automatic wr_hi(logic [31:0] v);
    hi_wr = 1; wdata = v; cyc(); hi_wr = 0;
  endtask
  task automatic tk(logic [63:0] c);
    count = c; tick = 1; cyc(); tick = 0; cyc();
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f0;
    cyc(3);
    rst_n = 1;
    cyc();
    cur_req = "R1";
    chk("R1 cmp", cmp_o, '1);
    chk("R1 cfg", {32'd0, cfg_o}, 64'h30);
    chk("R1 fire", {63'd0, fire_o}, 64'd0);

    cur_req = "R3";
    wr_cfg(32'hFFFF_FFF0); cyc();
    chk("R3 cfg ro bits", {32'd0, cfg_o}, 64'h30);
    wr_cfg(32'h0);

    cur_req = "R2";
    glb = 1; cyc();
    wr_lo(100); wr_hi(0); wr_cfg(32'h1);
    f0 = n_fire;
    tk(90);
    chk("R2 early", n_fire - f0, 0);
    tk(100);
    chk("R2 match", n_fire - f0, 1);
    tk(101); tk(105);
    chk("R2 single", n_fire - f0, 1);

    cur_req = "R13";
    wr_lo(150);
    f0 = n_fire;
    count = 200; cyc(3);
    chk("R13 no tick", n_fire - f0, 0);
    tk(200);
    chk("R12 rearm by write", n_fire - f0, 1);

    cur_req = "R10";
    wr_lo(400); wr_cfg(32'h0);
    f0 = n_fire;
    tk(400);
    chk("R10 en fall", n_fire - f0, 0);
    wr_cfg(32'h1); tk(401);
    chk("R10 en rise", n_fire - f0, 1);

    cur_req = "R11";
    glb = 0; cyc(); wr_lo(300); glb = 1; cyc();
    f0 = n_fire;
    tk(300);
    chk("R11 glb rise rearm", n_fire - f0, 1);
    glb = 0; cyc(); wr_lo(32'hFFFF_FFFF); wr_hi(32'hFFFF_FFFF); glb = 1; cyc();
    chk("R11 cmp ones", cmp_o, '1);
    tk(16);
    chk("R11 no rearm", n_fire - f0, 1);

    cur_req = "R5";
    wr_cfg(32'h6); wr_lo(1000); cyc();
    chk("R6 sv clear lo", {32'd0, cfg_o}, 64'h32);
    wr_cfg(32'h6); wr_hi(0); cyc();
    chk("R5 sv hi loads cmp", cmp_o, 64'd1000);
    chk("R6 sv clear hi", {32'd0, cfg_o}, 64'h32);

    cur_req = "R4";
    wr_cfg(32'h3);
    f0 = n_fire;
    tk(1000);
    chk("R4 advance", cmp_o, 64'd2000);
    tk(5500); cyc(6);
    chk("R4 catchup", cmp_o, 64'd6000);
    chk("R4 one fire each", n_fire - f0, 2);

    cur_req = "R5";
    wr_lo(50); cyc();
    chk("R5 period only", cmp_o, 64'd6000);
    tk(6000);
    chk("R5 new period", cmp_o, 64'd6050);

    cur_req = "R7";
    wr_hi(32'hFFFF_FFFF); cyc();
    chk("R7 cmp kept", cmp_o, 64'd6050);
    tk(6050); cyc(2);
    chk("R7 msb masked 64", cmp_o, 64'h7FFF_FFFF_0000_17D4);

    cur_req = "R8";
    wr_cfg(32'h8); cyc();
    chk("R8 truncate", cmp_o, 64'h17D4);
    wr_lo(32'h10);
    count = 64'h5_FFFF_FFF0; cyc();
    wr_cfg(32'h9);
    f0 = n_fire;
    tk(64'h5_FFFF_FFF8);
    chk("R8 signed32 no match", n_fire - f0, 0);

    cur_req = "R9";
    tk(64'h6_0000_0000);
    chk("R9 wrap fire", n_fire - f0, 1);
    tk(64'h6_0000_0008);
    chk("R9 hold", n_fire - f0, 1);
    tk(64'h6_0000_0010);
    chk("R9 real match", n_fire - f0, 2);
    tk(64'h6_0000_0020);
    chk("R9 done", n_fire - f0, 2);

    cur_req = "R8";
    wr_cfg(32'hF); wr_lo(32'hFFFF_FFF0);
    tk(64'h6_FFFF_FFF0); cyc(3);
    chk("R8 wrap add / R7 msb32", cmp_o, 64'h7FFF_FFE0);
    chk("R8 periodic fired", n_fire - f0, 3);

    cyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule